// File: doc/BRIEF.md
# SIMD Lane Predicate Mask Stack

This block keeps the active-lane mask of a 16-lane vector unit while the unit runs divergent if/else regions. A vector compare produces one condition bit per lane. The sequencer then issues a fixed series of commands: save the current mask, enter the true side, enter the false side, and restore the mask. The mask drives the unit's lane-writeback enables.

Each side of a branch has its own any-lane flag. The flag covers only lanes that are active in the saved mask. The sequencer reads the flag to skip a side that no lane needs. A branch therefore resolves into one taken or not-taken outcome per side.

Saved masks sit in a stack of parameterised depth, so regions can nest. Saving when the stack is full, or restoring when it is empty, raises a one-cycle error flag and changes nothing.

Top module: `lane_mask_stack`

## Requirements
- R1: After reset, `active_mask` is all ones, both error flags are low, and the stack is empty, so a first restore raises `underflow`.
- R2: Command 1 (save) pushes the current mask onto the stack. `active_mask` stays unchanged.
- R3: Command 2 (enter true) sets `active_mask` to the saved mask ANDed with `cond`, in the cycle after the command. The saved mask is the stack top, or the current mask when the stack is empty.
- R4: Command 3 (enter false) sets `active_mask` to the saved mask ANDed with the inverse of `cond`. It does not use the true-side mask.
- R5: Command 4 (restore) pops the stack top into `active_mask`. Nested regions restore in last-in, first-out order.
- R6: `any_true` is the OR of `cond` AND the saved mask. `any_false` is the OR of the inverse of `cond` AND the saved mask. Both are combinational, in the same cycle as `cond`, so inactive lanes never raise either flag.
- R7: A save with DEPTH entries on the stack raises `overflow` for exactly the next cycle. The mask and the stack contents stay unchanged.
- R8: A restore with an empty stack raises `underflow` for exactly the next cycle. The mask stays unchanged.
- R9: Command 0 (idle) and the unused codes 5 to 7 leave `active_mask` unchanged, whatever `cond` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Command: 0 idle, 1 save, 2 enter true, 3 enter false, 4 restore |
| cond | input | 16 | Per-lane condition from the vector compare |
| active_mask | output | 16 | Current active-lane mask |
| any_true | output | 1 | Some saved-active lane has its condition set |
| any_false | output | 1 | Some saved-active lane has its condition clear |
| overflow | output | 1 | One-cycle pulse after a save into a full stack |
| underflow | output | 1 | One-cycle pulse after a restore from an empty stack |

## Verification
The any-lane flags have no register in their path. The bench therefore drives `cmd` and `cond` at a falling edge and reads the flags 1 ns later, before the next rising edge. `active_mask` and both error pulses each pass through one register. The bench reads them at the falling edge that follows the rising edge that took the command, after it has returned `cmd` to idle. A reference model in the bench updates the expected mask and stack only after it has checked the flags, so each flag is compared against the state as it stood before the command.

// File: rtl/lms_pkg.sv
// Shared command encoding for the lane mask stack.
package lms_pkg;
    typedef enum logic [2:0] {
        CMD_IDLE    = 3'd0,
        CMD_SAVE    = 3'd1,
        CMD_TAKE_T  = 3'd2,
        CMD_TAKE_F  = 3'd3,
        CMD_RESTORE = 3'd4
    } lms_cmd_e;
endpackage

// File: rtl/lms_lane_any.sv
// OR-reduces a lane vector into one "some lane set" bit, using a balanced tree.
// Assumes LANES >= 1. Purely combinational.
module lms_lane_any #(
    parameter int LANES = 16
) (
    input  logic [LANES-1:0] vec_i,
    output logic             any_o
);
    localparam int LVLS = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int PAD  = 1 << LVLS;

    logic [PAD-1:0] stage [LVLS+1];

    // Pad the input with zeros up to a power of two.
    always_comb begin
        stage[0] = '0;
        stage[0][LANES-1:0] = vec_i;
    end

    // Each level ORs adjacent pairs from the level below.
    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        for (genvar i = 0; i < PAD; i++) begin : g_bit
            if (i < (PAD >> (l + 1))) begin : g_or
                assign stage[l+1][i] = stage[l][2*i] | stage[l][2*i+1];
            end else begin : g_zero
                assign stage[l+1][i] = 1'b0;
            end
        end
    end

    assign any_o = stage[LVLS][0];
endmodule

// File: rtl/lms_mask_store.sv
// LIFO holding saved lane masks. A push into a full store or a pop from an
// empty store is ignored; the caller reports the error. Assumes DEPTH >= 2
// and that the caller never asserts push_i and pop_i together.
module lms_mask_store #(
    parameter int LANES = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [LANES-1:0] data_i,
    output logic [LANES-1:0] top_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic [PW-1:0]    sp_q;
    logic [LANES-1:0] mem_q [DEPTH];
    logic [IW-1:0]    wr_idx;
    logic [IW-1:0]    rd_idx;

    // Decode the fill level and the slot indices from the pointer.
    always_comb begin
        empty_o = (sp_q == '0);
        full_o  = (sp_q == PW'(DEPTH));
        wr_idx  = sp_q[IW-1:0];
        rd_idx  = wr_idx - IW'(1);
        top_o   = mem_q[rd_idx];
    end

    // Move the stack pointer on an accepted push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (push_i && !full_o) begin
            sp_q <= sp_q + PW'(1);
        end else if (pop_i && !empty_o) begin
            sp_q <= sp_q - PW'(1);
        end
    end

    // Write the pushed mask into the next free slot.
    always_ff @(posedge clk) begin
        if (push_i && !full_o) begin
            mem_q[wr_idx] <= data_i;
        end
    end

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= PW'(DEPTH)); // R7
    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o) |=> !empty_o); // R2
    AST_POP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o) |=> !full_o); // R5
endmodule

// File: rtl/lane_mask_stack.sv
// Active-lane mask controller for divergent if/else regions. It holds the
// current mask, pushes and pops saved masks, forms the true-side and
// false-side masks from the saved mask, and reports per side whether any lane
// needs that side. Assumes one command per cycle, encoded as in lms_pkg.
module lane_mask_stack #(
    parameter int LANES = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] active_mask,
    output logic             any_true,
    output logic             any_false,
    output logic             overflow,
    output logic             underflow
);
    import lms_pkg::*;

    logic [LANES-1:0] mask_q, mask_d;
    logic [LANES-1:0] saved, top;
    logic             st_empty, st_full;
    logic             push, pop;
    logic             ovf_q, ovf_d, udf_q, udf_d;
    logic [LANES-1:0] t_lanes, f_lanes;

    // The saved mask is the stack top, or the live mask when nothing is saved.
    always_comb begin
        saved   = st_empty ? mask_q : top;
        t_lanes = saved & cond;
        f_lanes = saved & ~cond;
    end

    // Decode the command into the next mask, the stack moves and the error flags.
    always_comb begin
        mask_d = mask_q;
        push   = 1'b0;
        pop    = 1'b0;
        ovf_d  = 1'b0;
        udf_d  = 1'b0;
        case (cmd)
            CMD_SAVE: begin
                if (st_full) ovf_d = 1'b1;
                else         push  = 1'b1;
            end
            CMD_TAKE_T: mask_d = t_lanes;
            CMD_TAKE_F: mask_d = f_lanes;
            CMD_RESTORE: begin
                if (st_empty) begin
                    udf_d = 1'b1;
                end else begin
                    pop    = 1'b1;
                    mask_d = top;
                end
            end
            default: ;
        endcase
    end

    // Register the active mask and the one-cycle error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            ovf_q  <= 1'b0;
            udf_q  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            ovf_q  <= ovf_d;
            udf_q  <= udf_d;
        end
    end

    lms_mask_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .data_i  (mask_q),
        .top_o   (top),
        .empty_o (st_empty),
        .full_o  (st_full)
    );

    lms_lane_any #(.LANES(LANES)) u_any_t (.vec_i(t_lanes), .any_o(any_true));
    lms_lane_any #(.LANES(LANES)) u_any_f (.vec_i(f_lanes), .any_o(any_false));

    assign active_mask = mask_q;
    assign overflow    = ovf_q;
    assign underflow   = udf_q;

    AST_RESET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '1)); // R1
    AST_SAVE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_SAVE) |=> $stable(mask_q)); // R2
    AST_TRUE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_TAKE_T) |=> ((mask_q & ~$past(cond)) == '0)); // R3
    AST_FALSE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_TAKE_F) |=> ((mask_q & $past(cond)) == '0)); // R4
    AST_OVERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (mask_q == $past(mask_q))); // R7
    AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (mask_q == $past(mask_q))); // R8
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow)); // R7
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_IDLE) |=> $stable(mask_q)); // R9
endmodule

// File: tb/lane_mask_stack_tb.sv
// Directed bench for lane_mask_stack: one task per scenario, checked against
// a small reference model of the mask and the saved-mask stack.
module lane_mask_stack_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [15:0] cond = '0;
    logic [15:0] active_mask;
    logic        any_true, any_false, overflow, underflow;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_mask;
    logic [15:0] m_stk [8];
    int          m_sp;

    always #10 clk = ~clk;

    lane_mask_stack u_dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cond(cond),
        .active_mask(active_mask), .any_true(any_true), .any_false(any_false),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one command, check the same-cycle flags, then the registered results.
    task automatic run(input logic [2:0] c, input logic [15:0] cv, input string req);
        logic [15:0] base;
        bit eo, eu;
        @(negedge clk);
        cmd = c; cond = cv;
        #1;
        base = (m_sp == 0) ? m_mask : m_stk[m_sp-1];
        chk("R6 any_true", int'(any_true), int'(|(cv & base)));
        chk("R6 any_false", int'(any_false), int'(|(~cv & base)));
        eo = 0; eu = 0;
        case (c)
            3'd1: if (m_sp == 8) eo = 1; else begin m_stk[m_sp] = m_mask; m_sp++; end
            3'd2: m_mask = base & cv;
            3'd3: m_mask = base & ~cv;
            3'd4: if (m_sp == 0) eu = 1; else begin m_sp--; m_mask = m_stk[m_sp]; end
            default: ;
        endcase
        @(negedge clk);
        cmd = 3'd0;
        chk(req, int'(active_mask), int'(m_mask));
        chk("R7 overflow", int'(overflow), int'(eo));
        chk("R8 underflow", int'(underflow), int'(eu));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_mask = 16'hFFFF; m_sp = 0;
        @(negedge clk);
        chk("R1 mask", int'(active_mask), 16'hFFFF);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 underflow", int'(underflow), 0);
        run(3'd4, 16'h0000, "R1 restore on empty");
    endtask

    task automatic t_if_else();
        run(3'd1, 16'h00F3, "R2 save keeps mask");
        run(3'd2, 16'h00F3, "R3 true side");
        run(3'd3, 16'h00F3, "R4 false side from saved");
        run(3'd4, 16'h0000, "R5 restore");
    endtask

    task automatic t_nested();
        run(3'd1, 16'h0FF0, "R2 outer save");
        run(3'd2, 16'h0FF0, "R3 outer true");
        run(3'd1, 16'h00FF, "R2 inner save");
        run(3'd2, 16'h00FF, "R3 inner true");
        run(3'd3, 16'h00FF, "R4 inner false");
        run(3'd4, 16'h0000, "R5 inner restore");
        run(3'd4, 16'h0000, "R5 outer restore");
    endtask

    task automatic t_empty_side();
        run(3'd1, 16'h00F0, "R2 save");
        run(3'd2, 16'h00F0, "R3 narrow true");
        run(3'd1, 16'hFF0F, "R2 save narrow");
        run(3'd2, 16'hFF0F, "R6 true side empty within saved lanes");
        run(3'd3, 16'hFFFF, "R6 false side empty");
        run(3'd4, 16'h0000, "R5 restore");
        run(3'd4, 16'h0000, "R5 restore");
    endtask

    task automatic t_idle();
        run(3'd1, 16'h0000, "R2 save");
        run(3'd2, 16'h3C3C, "R3 true");
        run(3'd0, 16'hFFFF, "R9 idle keeps mask");
        run(3'd5, 16'h0000, "R9 code 5 keeps mask");
        run(3'd7, 16'h1234, "R9 code 7 keeps mask");
        run(3'd4, 16'h0000, "R5 restore");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 8; i++) begin
            run(3'd1, 16'h0000, "R2 fill");
            run(3'd2, 16'hFFFF >> i, "R3 fill true");
        end
        run(3'd1, 16'h0000, "R7 save when full keeps mask");
        for (int i = 0; i < 8; i++) begin
            run(3'd4, 16'h0000, "R5 drain order");
        end
        run(3'd4, 16'h0000, "R8 restore when empty keeps mask");
    endtask

    initial begin
        t_reset();
        t_if_else();
        t_nested();
        t_empty_side();
        t_idle();
        t_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule